// File: doc/BRIEF.md
# FIFO Read Bus-Width Unpacker

This block sits on the output side of a 36-bit FIFO and feeds a single output bus. Each long word leaves the FIFO as a whole and is handed to the bus in one of three ways: as one 36-bit transfer, as two 18-bit halves, or as four 9-bit bytes. A lane-side bit chooses where a narrow transfer sits on the bus and which part of the long word comes first. When that bit is set, the upper lanes carry the data and the most significant part goes first. When it is clear, the lower lanes carry the data and the least significant part goes first.

Before the word is split, a 2-bit code can rearrange its four bytes. The order of bits inside each byte never changes. The swap code is taken from the read that pulls the word out of the FIFO, and it stays in force until the last part of that word has gone out. Parts not yet delivered wait in a holding register. A read under a different size or lane-side selection abandons them and fetches a fresh word. Output lanes outside the active part keep the value they last carried.

The FIFO presents its head word on `fifo_data`. Asserting `fifo_pop` consumes that word in the same cycle.

Top module: `fifo_read_unpacker`

## Requirements
- R1: While reset is held, and after it is released, `dout` is zero. `fifo_pop` stays low until a read is requested.
- R2: The size code is 00 or 11 for a 36-bit long word, 01 for two 18-bit halves, and 10 for four 9-bit bytes. The size code and `big_end` are registered on every rising edge. A read on a given edge uses the values registered on the edge before it.
- R3: In long-word mode, every read with the FIFO not empty pulses `fifo_pop` and loads the whole (swapped) word into `dout`.
- R4: In half mode, the read that fetches a word pulses `fifo_pop` and delivers the first half. The next read delivers the second half from the holding register, without a pop. With `big_end`=1 the halves go to `dout[35:18]`, bits 35:18 first. With `big_end`=0 they go to `dout[17:0]`, bits 17:0 first.
- R5: In byte mode, the fetching read pops and delivers the first byte. The next three reads deliver the rest without a pop. With `big_end`=1 the bytes go to `dout[35:27]` in the order 35:27, 26:18, 17:9, 8:0. With `big_end`=0 they go to `dout[8:0]` in the reverse order.
- R6: During a narrow read, the bits of `dout` outside the active lanes keep their previous values.
- R7: The swap code is applied before splitting. Label the bytes of the FIFO word B3 (bits 35:27) down to B0. Code 00 leaves them as B3 B2 B1 B0. Code 01 gives B0 B1 B2 B3. Code 10 exchanges the 18-bit halves, giving B1 B0 B3 B2. Code 11 swaps the bytes inside each half, giving B2 B3 B0 B1.
- R8: The swap code is sampled only on a fetching read. Later reads of the same word ignore it.
- R9: A read whose registered size or `big_end` differs from the selection in force when the held word was fetched pops a new word. Any held parts are discarded.
- R10: A read that needs a new word while `fifo_empty` is high does not pop and leaves `dout` unchanged.
- R11: While parts of a word remain held and the selection is unchanged, reads deliver them with no pop, even when `fifo_empty` is high.
- R12: With `rd_en` low, `fifo_pop` is low and `dout` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| size_sel | input | 2 | Transfer size code, registered each edge |
| big_end | input | 1 | Lane side and part order, registered each edge |
| swap_sel | input | 2 | Byte rearrangement code |
| rd_en | input | 1 | Read strobe |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | 36 | Head word of the FIFO |
| fifo_pop | output | 1 | Consume the head word this cycle |
| dout | output | 36 | Registered output bus |

## Verification
The hardest case to reach from the ports is the one-cycle gap between a size or `big_end` change and the edge that obeys it. A read issued on the same edge as the change must still follow the old selection, and only the next read may fetch and discard. The stimulus changes `size_sel` and raises `rd_en` in the same cycle. It then checks that this read pops and delivers a full long word, and that the following read pops again and places a single byte. Held-part behaviour is reached by fetching a word in byte mode and then raising `fifo_empty` while the remaining bytes are read out. A further read is then made with nothing held, and another after a mode change while the FIFO is still empty.

// File: rtl/fifo_read_unpacker.sv
module fifo_read_unpacker #(
  parameter int LANE_W = 9,
  localparam int W = 4 * LANE_W,
  localparam int HALF = 2 * LANE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   size_sel,
  input  logic         big_end,
  input  logic [1:0]   swap_sel,
  input  logic         rd_en,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_data,
  output logic         fifo_pop,
  output logic [W-1:0] dout
);

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_BYTE = 2'b10;

  logic [1:0]        size_q, live_size, left, parts_m1, idx;
  logic              be_q, live_be, need_fetch, take;
  logic [W-1:0]      held, swapped, src, nxt;
  logic [LANE_W-1:0] bpart;
  logic [HALF-1:0]   hpart;
  logic [LANE_W-1:0] b0, b1, b2, b3;

  assign b0 = fifo_data[0*LANE_W +: LANE_W];
  assign b1 = fifo_data[1*LANE_W +: LANE_W];
  assign b2 = fifo_data[2*LANE_W +: LANE_W];
  assign b3 = fifo_data[3*LANE_W +: LANE_W];

  always_comb begin
    case (swap_sel)
      2'b01:   swapped = {b0, b1, b2, b3};
      2'b10:   swapped = {b1, b0, b3, b2};
      2'b11:   swapped = {b2, b3, b0, b1};
      default: swapped = {b3, b2, b1, b0};
    endcase
  end

  always_comb begin
    case (size_q)
      SZ_HALF: parts_m1 = 2'd1;
      SZ_BYTE: parts_m1 = 2'd3;
      default: parts_m1 = 2'd0;
    endcase
  end

  assign need_fetch = (left == 2'd0) || (size_q != live_size) || (be_q != live_be);
  assign fifo_pop   = rd_en && need_fetch && !fifo_empty;
  assign take       = rd_en && (fifo_pop || !need_fetch);
  assign src        = fifo_pop ? swapped : held;
  assign idx        = fifo_pop ? 2'd0 : 2'(parts_m1 - left + 2'd1);

  always_comb begin
    if (be_q) bpart = src[(3 - idx) * LANE_W +: LANE_W];
    else      bpart = src[idx * LANE_W +: LANE_W];
    if (be_q ^ idx[0]) hpart = src[W-1:HALF];
    else               hpart = src[HALF-1:0];
  end

  always_comb begin
    nxt = dout;
    case (size_q)
      SZ_HALF: begin
        if (be_q) nxt[W-1:HALF] = hpart;
        else      nxt[HALF-1:0] = hpart;
      end
      SZ_BYTE: begin
        if (be_q) nxt[W-1 -: LANE_W] = bpart;
        else      nxt[LANE_W-1:0]   = bpart;
      end
      default: nxt = src;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q    <= SZ_LONG;
      be_q      <= 1'b0;
      live_size <= SZ_LONG;
      live_be   <= 1'b0;
      left      <= 2'd0;
      held      <= '0;
      dout      <= '0;
    end else begin
      size_q <= (size_sel == 2'b11) ? SZ_LONG : size_sel;
      be_q   <= big_end;
      if (take) dout <= nxt;
      if (fifo_pop) begin
        held      <= swapped;
        live_size <= size_q;
        live_be   <= be_q;
        left      <= parts_m1;
      end else if (take) begin
        left <= left - 2'd1;
      end
    end
  end

endmodule

module fifo_read_unpacker_chk #(
  parameter int W = 36,
  parameter int LW = 9
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   size_sel,
  input logic         big_end,
  input logic         rd_en,
  input logic         fifo_empty,
  input logic         fifo_pop,
  input logic [W-1:0] dout,
  input logic [1:0]   left
);

  logic [1:0] sz_c;
  logic       be_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sz_c <= 2'b00;
      be_c <= 1'b0;
    end else begin
      sz_c <= size_sel;
      be_c <= big_end;
    end
  end

  assert_pop_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (rd_en && !fifo_empty));

  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(dout));

  assert_long_pops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !fifo_empty && (sz_c == 2'b00 || sz_c == 2'b11)) |-> fifo_pop);

  assert_upper_byte_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sz_c == 2'b10 && be_c) |=> dout[W-LW-1:0] == $past(dout[W-LW-1:0]));

  assert_lower_byte_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sz_c == 2'b10 && !be_c) |=> dout[W-1:LW] == $past(dout[W-1:LW]));

  assert_empty_no_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fifo_empty && left == 2'd0) |=> $stable(dout));

endmodule

bind fifo_read_unpacker fifo_read_unpacker_chk #(.W(W), .LW(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .big_end(big_end),
  .rd_en(rd_en), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
  .dout(dout), .left(left)
);

// File: tb/fifo_read_unpacker_test.sv
module fifo_read_unpacker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size_sel = 2'b00;
  logic        big_end = 1'b0;
  logic [1:0]  swap_sel = 2'b00;
  logic        rd_en = 1'b0;
  logic        fifo_empty = 1'b1;
  logic [35:0] fifo_data = '0;
  logic        fifo_pop;
  logic [35:0] dout;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [35:0] exp_out = '0;

  always #5 clk = ~clk;

  fifo_read_unpacker uut (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .big_end(big_end),
    .swap_sel(swap_sel), .rd_en(rd_en), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_pop(fifo_pop), .dout(dout)
  );

  // size(2) be(1) swap(2) data(36)
  localparam logic [40:0] VEC [8] = '{
    {2'b00, 1'b0, 2'b00, 36'h123456789},
    {2'b11, 1'b1, 2'b01, 36'hABCDEF012},
    {2'b01, 1'b0, 2'b00, 36'h0F0F0F0F0},
    {2'b01, 1'b1, 2'b10, 36'h987654321},
    {2'b10, 1'b0, 2'b11, 36'h13579BDF1},
    {2'b10, 1'b1, 2'b01, 36'h2468ACE02},
    {2'b01, 1'b1, 2'b11, 36'hFEDCBA987},
    {2'b10, 1'b0, 2'b10, 36'h5A5A5A5A5}
  };

  function automatic logic [35:0] swp(logic [35:0] d, logic [1:0] s);
    logic [8:0] x3 = d[35:27], x2 = d[26:18], x1 = d[17:9], x0 = d[8:0];
    case (s)
      2'b01:   return {x0, x1, x2, x3};
      2'b10:   return {x1, x0, x3, x2};
      2'b11:   return {x2, x3, x0, x1};
      default: return d;
    endcase
  endfunction

  function automatic int nparts(logic [1:0] sz);
    return (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 1;
  endfunction

  function automatic logic [35:0] place(logic [35:0] old, logic [35:0] w,
                                        logic [1:0] sz, logic be, int p);
    logic [35:0] r = old;
    if (sz == 2'b01) begin
      logic [17:0] h = ((p == 0) == be) ? w[35:18] : w[17:0];
      if (be) r[35:18] = h; else r[17:0] = h;
    end else if (sz == 2'b10) begin
      int k = be ? 3 - p : p;
      if (be) r[35:27] = w[k*9 +: 9]; else r[8:0] = w[k*9 +: 9];
    end else begin
      r = w;
    end
    return r;
  endfunction

  task automatic check(logic [35:0] act, logic [35:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(logic [1:0] sz, logic be);
    @(negedge clk);
    size_sel = sz; big_end = be; rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_read(logic [1:0] sw, logic [35:0] d, logic emp,
                         logic exp_pop, string tag);
    rd_en = 1'b1; swap_sel = sw; fifo_data = d; fifo_empty = emp;
    #1 check({35'd0, fifo_pop}, {35'd0, exp_pop}, {tag, " pop"});
    @(negedge clk);
    rd_en = 1'b0;
    check(dout, exp_out, {tag, " dout"});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [35:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check(dout, 36'h0, "R1 reset dout");
    check({35'd0, fifo_pop}, 36'h0, "R1 reset pop");
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic [1:0] sz = VEC[v][40:39];
      logic       be = VEC[v][38];
      logic [1:0] sw = VEC[v][37:36];
      logic [35:0] d = VEC[v][35:0];
      set_mode(sz, be);
      w = swp(d, sw);
      for (int p = 0; p < nparts(sz); p++) begin
        exp_out = place(exp_out, w, sz, be, p);
        if (p == 0) do_read(sw, d, 1'b0, 1'b1, "R2 R3 R4 R5 R7 fetch");
        else        do_read(~sw, 36'hFFFFFFFFF, 1'b0, 1'b0, "R4 R5 R6 R8 held");
      end
    end

    // R2: size change on the same edge as a read uses the old size
    set_mode(2'b00, 1'b0);
    size_sel = 2'b10;
    exp_out = 36'h111222333;
    do_read(2'b00, 36'h111222333, 1'b0, 1'b1, "R2 old size");
    exp_out = place(exp_out, 36'h0AB0CD0EF, 2'b10, 1'b0, 0);
    do_read(2'b00, 36'h0AB0CD0EF, 1'b0, 1'b1, "R2 new size");

    // R9: size change discards held bytes
    set_mode(2'b01, 1'b0);
    exp_out = place(exp_out, 36'h777888999, 2'b01, 1'b0, 0);
    do_read(2'b00, 36'h777888999, 1'b0, 1'b1, "R9 size change");
    set_mode(2'b01, 1'b1);
    exp_out = place(exp_out, 36'h314159265, 2'b01, 1'b1, 0);
    do_read(2'b00, 36'h314159265, 1'b0, 1'b1, "R9 endian change");

    // R11: held bytes delivered while FIFO empty
    set_mode(2'b10, 1'b1);
    w = 36'h8ABCDE123;
    exp_out = place(exp_out, w, 2'b10, 1'b1, 0);
    do_read(2'b00, w, 1'b0, 1'b1, "R11 fetch");
    for (int p = 1; p < 4; p++) begin
      exp_out = place(exp_out, w, 2'b10, 1'b1, p);
      do_read(2'b01, 36'h0, 1'b1, 1'b0, "R11 empty held");
    end

    // R10: empty with nothing held, then mode change while empty
    do_read(2'b00, 36'h555555555, 1'b1, 1'b0, "R10 empty idle");
    set_mode(2'b00, 1'b0);
    do_read(2'b00, 36'h666666666, 1'b1, 1'b0, "R10 empty new mode");

    // R12: no read strobe
    fifo_empty = 1'b0; fifo_data = 36'h999999999; rd_en = 1'b0;
    #1 check({35'd0, fifo_pop}, 36'h0, "R12 no strobe pop");
    repeat (3) @(negedge clk);
    check(dout, exp_out, "R12 no strobe dout");

    finish_run();
  end

endmodule